// File: doc/BRIEF.md
# Address-Window Burst Funnel

This block is the write front end of a bus target. It decodes one large, aligned memory window and sends every data word written anywhere in that window into a single 16-entry FIFO. A master can therefore stream data into one sink using ordinary incrementing bursts. The bus carries the address only on the start strobe, so the block keeps its own running address for each later data phase. It disconnects when the FIFO cannot take the word, when the burst reaches the last word of the window, or after every data phase when the legacy single-address mode is selected.

After a disconnect the master is expected to restart at the next address it has not yet written. The block compares that restart address with its own tracked address. A mismatch is accepted as the start of a new stream, and it also raises a sticky error output. The consumer side drains the FIFO through a synchronous read port with an empty flag. Each entry holds the data word with its byte enables above it.

Top module: `wfunnel_top`

## Requirements
- R1: After reset the FIFO reads empty, the sequence error output is low, and ready and stop are both low.
- R2: A start strobe whose address lies in the window `[WIN_BASE, WIN_BASE + 2^WIN_LOG2)` (default 0x0040_0000 and 4 MB) opens a burst, and ready rises on the next cycle. A start outside the window closes any open burst, opens none, and stores no words.
- R3: A data phase is accepted when valid and ready are both high in the same cycle. Each accepted phase is stored in arrival order as one entry, with the data in bits [31:0] and the byte enables in [35:32], and it advances the tracked address by 4 bytes.
- R4: When the FIFO holds 16 entries, a data phase sees ready low and stop high. The word is not stored, and no entry is ever overwritten or lost.
- R5: The data phase at the last word address of the window (offset 0x3F_FFFC) is accepted with stop high. Any stop closes the burst, so ready stays low until the next start.
- R6: With the single-address mode input high, the first data phase of a burst is accepted with stop high.
- R7: After a disconnect that was not at the window end, a restart at the tracked next address continues the stream and leaves the error output low.
- R8: A restart at any other in-window address opens a burst at that address and sets the error output. The error output then stays high until reset.
- R9: A read request while the FIFO is not empty presents the oldest entry on the read data the cycle after. A read request while the FIFO is empty changes nothing.
- R10: The words read out equal the accepted words, with none dropped and none duplicated, including across full-FIFO disconnects and restarts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_single_i | input | 1 | Legacy mode: disconnect after each data phase |
| bus_start_i | input | 1 | Address phase strobe (start or restart of a burst) |
| bus_addr_i | input | 32 | Byte address, valid with the start strobe |
| bus_valid_i | input | 1 | Master presents a data phase |
| bus_data_i | input | 32 | Write data |
| bus_be_i | input | 4 | Byte enables |
| bus_ready_o | output | 1 | Target accepts the data phase this cycle |
| bus_stop_o | output | 1 | Target disconnects the burst this cycle |
| rd_en_i | input | 1 | Consumer read request |
| rd_data_o | output | 36 | Read entry {byte enables, data} |
| rd_empty_o | output | 1 | FIFO holds no entries |
| seq_err_o | output | 1 | Sticky restart-address mismatch |

## Verification
The main path is driven with several burst shapes. A plain in-window burst shows that words are stored in order. An out-of-window start shows the decode refusing, and a burst that straddles the window end shows the address tracking stopping at the right phase. Single-address mode shows the disconnect after one phase. A correct restart after single mode, followed by a wrong one, separates the continuation case from the mismatch case and shows that the error flag stays set. Directed runs fill the FIFO past capacity, drain part of it, and restart at the tracked address, so that a dropped or duplicated word around the full-stop shows up. An empty read checks that the read pointer does not move.

// File: rtl/wfunnel_pkg.sv
package wfunnel_pkg;
    // reason the target ends a data phase with stop
    typedef enum logic [1:0] {
        STOP_NONE   = 2'd0,
        STOP_FULL   = 2'd1,
        STOP_END    = 2'd2,
        STOP_SINGLE = 2'd3
    } stop_cause_e;
endpackage

// File: rtl/wfunnel_decode.sv
module wfunnel_decode #(
    parameter int                ADDR_W    = 32,
    parameter int                WIN_LOG2  = 22,
    parameter int                LANE_LOG2 = 2,
    parameter logic [ADDR_W-1:0] WIN_BASE  = 32'h0040_0000
) (
    input  logic [ADDR_W-1:0] start_addr_i,
    input  logic [ADDR_W-1:0] run_addr_i,
    output logic              hit_o,
    output logic              at_end_o
);
    generate
        if (WIN_LOG2 >= ADDR_W) begin : g_all
            assign hit_o = 1'b1;
        end else begin : g_cmp
            assign hit_o = (start_addr_i[ADDR_W-1:WIN_LOG2] == WIN_BASE[ADDR_W-1:WIN_LOG2]);
        end
    endgenerate

    // last word of the window: all word-offset bits set
    assign at_end_o = &run_addr_i[WIN_LOG2-1:LANE_LOG2];
endmodule

// File: rtl/wfunnel_track.sv
module wfunnel_track
    import wfunnel_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int STEP   = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_single_i,
    input  logic              start_i,
    input  logic [ADDR_W-1:0] start_addr_i,
    input  logic              start_hit_i,
    input  logic              valid_i,
    input  logic              fifo_full_i,
    input  logic              at_end_i,
    output logic [ADDR_W-1:0] run_addr_o,
    output logic              ready_o,
    output logic              stop_o,
    output logic              push_o,
    output logic              seq_err_o
);
    typedef struct packed {
        logic              active;
        logic              pending;
        logic              err;
        logic [ADDR_W-1:0] addr;
    } st_t;

    st_t         s_d, s_q;
    stop_cause_e cause;
    logic        ready, push;

    always_comb begin
        s_d   = s_q;
        cause = STOP_NONE;
        ready = s_q.active && !fifo_full_i && !start_i;
        push  = ready && valid_i;

        if (s_q.active && valid_i && !start_i) begin
            if (fifo_full_i)       cause = STOP_FULL;
            else if (at_end_i)     cause = STOP_END;
            else if (cfg_single_i) cause = STOP_SINGLE;
        end

        if (start_i) begin
            s_d.pending = 1'b0;
            s_d.active  = start_hit_i;
            if (start_hit_i) begin
                if (s_q.pending && (start_addr_i != s_q.addr)) s_d.err = 1'b1;
                s_d.addr = start_addr_i;
            end
        end else begin
            if (push) s_d.addr = s_q.addr + ADDR_W'(STEP);
            if (cause != STOP_NONE) begin
                s_d.active  = 1'b0;
                s_d.pending = (cause != STOP_END);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign run_addr_o = s_q.addr;
    assign ready_o    = ready;
    assign push_o     = push;
    assign stop_o     = (cause != STOP_NONE);
    assign seq_err_o  = s_q.err;
endmodule

// File: rtl/wfunnel_fifo.sv
module wfunnel_fifo #(
    parameter int W    = 36,
    parameter int LOG2 = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         push_i,
    input  logic [W-1:0] wdata_i,
    input  logic         pop_i,
    output logic [W-1:0] rdata_o,
    output logic         empty_o,
    output logic         full_o,
    output logic [LOG2:0] fill_o
);
    localparam int DEPTH = 1 << LOG2;

    typedef struct packed {
        logic [LOG2-1:0] wptr;
        logic [LOG2-1:0] rptr;
        logic [LOG2:0]   cnt;
        logic [W-1:0]    rdata;
    } st_t;

    st_t          s_d, s_q;
    logic [W-1:0] mem [DEPTH];
    logic         do_push, do_pop;

    always_comb begin
        s_d     = s_q;
        do_pop  = pop_i && (s_q.cnt != '0);
        do_push = push_i && (s_q.cnt != (LOG2+1)'(DEPTH));
        if (do_pop) begin
            s_d.rdata = mem[s_q.rptr];
            s_d.rptr  = s_q.rptr + 1'b1;
        end
        if (do_push) s_d.wptr = s_q.wptr + 1'b1;
        s_d.cnt = s_q.cnt + (LOG2+1)'(do_push) - (LOG2+1)'(do_pop);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    always_ff @(posedge clk) begin
        if (do_push) mem[s_q.wptr] <= wdata_i;
    end

    assign rdata_o = s_q.rdata;
    assign empty_o = (s_q.cnt == '0);
    assign full_o  = (s_q.cnt == (LOG2+1)'(DEPTH));
    assign fill_o  = s_q.cnt;
endmodule

// File: rtl/wfunnel_top.sv
module wfunnel_top #(
    parameter int          ADDR_W    = 32,
    parameter int          DATA_W    = 32,
    parameter int          WIN_LOG2  = 22,
    parameter int          FIFO_LOG2 = 4,
    parameter logic [31:0] WIN_BASE  = 32'h0040_0000
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        cfg_single_i,
    input  logic                        bus_start_i,
    input  logic [ADDR_W-1:0]           bus_addr_i,
    input  logic                        bus_valid_i,
    input  logic [DATA_W-1:0]           bus_data_i,
    input  logic [DATA_W/8-1:0]         bus_be_i,
    output logic                        bus_ready_o,
    output logic                        bus_stop_o,
    input  logic                        rd_en_i,
    output logic [DATA_W+DATA_W/8-1:0]  rd_data_o,
    output logic                        rd_empty_o,
    output logic                        seq_err_o
);
    localparam int BE_W      = DATA_W / 8;
    localparam int ENTRY_W   = DATA_W + BE_W;
    localparam int LANE_LOG2 = $clog2(BE_W);

    logic              hit, at_end, push, fifo_full;
    logic [ADDR_W-1:0] run_addr;
    logic [FIFO_LOG2:0] fifo_fill;

    wfunnel_decode #(
        .ADDR_W(ADDR_W), .WIN_LOG2(WIN_LOG2), .LANE_LOG2(LANE_LOG2),
        .WIN_BASE(ADDR_W'(WIN_BASE))
    ) u_dec (
        .start_addr_i(bus_addr_i), .run_addr_i(run_addr),
        .hit_o(hit), .at_end_o(at_end)
    );

    wfunnel_track #(.ADDR_W(ADDR_W), .STEP(BE_W)) u_trk (
        .clk(clk), .rst_n(rst_n), .cfg_single_i(cfg_single_i),
        .start_i(bus_start_i), .start_addr_i(bus_addr_i), .start_hit_i(hit),
        .valid_i(bus_valid_i), .fifo_full_i(fifo_full), .at_end_i(at_end),
        .run_addr_o(run_addr), .ready_o(bus_ready_o), .stop_o(bus_stop_o),
        .push_o(push), .seq_err_o(seq_err_o)
    );

    wfunnel_fifo #(.W(ENTRY_W), .LOG2(FIFO_LOG2)) u_fifo (
        .clk(clk), .rst_n(rst_n), .push_i(push), .wdata_i({bus_be_i, bus_data_i}),
        .pop_i(rd_en_i), .rdata_o(rd_data_o), .empty_o(rd_empty_o),
        .full_o(fifo_full), .fill_o(fifo_fill)
    );
endmodule

// File: rtl/wfunnel_chk.sv
module wfunnel_chk #(
    parameter int FIFO_LOG2 = 4
) (
    input logic               clk,
    input logic               rst_n,
    input logic               single,
    input logic               start,
    input logic               valid,
    input logic               ready,
    input logic               stop,
    input logic               full,
    input logic [FIFO_LOG2:0] fill,
    input logic               err,
    input logic               rd_en,
    input logic               empty
);
    localparam int DEPTH = 1 << FIFO_LOG2;

    a_r4_no_ready_when_full: assert property (@(posedge clk) disable iff (!rst_n)
        ready |-> !full);

    a_r4_fill_bounded: assert property (@(posedge clk) disable iff (!rst_n)
        fill <= (FIFO_LOG2+1)'(DEPTH));

    a_r4_stop_in_phase: assert property (@(posedge clk) disable iff (!rst_n)
        stop |-> valid);

    a_r5_stop_closes: assert property (@(posedge clk) disable iff (!rst_n)
        (stop && !start) |=> !ready);

    a_r6_single_stop: assert property (@(posedge clk) disable iff (!rst_n)
        (single && valid && ready) |-> stop);

    a_r8_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        err |=> err);

    a_r9_empty_read: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && empty && !(valid && ready)) |=> empty);
endmodule

bind wfunnel_top wfunnel_chk #(.FIFO_LOG2(FIFO_LOG2)) u_chk (
    .clk(clk), .rst_n(rst_n), .single(cfg_single_i), .start(bus_start_i),
    .valid(bus_valid_i), .ready(bus_ready_o), .stop(bus_stop_o),
    .full(fifo_full), .fill(fifo_fill), .err(seq_err_o),
    .rd_en(rd_en_i), .empty(rd_empty_o)
);

// File: tb/wfunnel_tb.sv
module wfunnel_top_tb_top;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_single = 1'b0, bus_start = 1'b0, bus_valid = 1'b0, rd_en = 1'b0;
    logic [31:0] bus_addr = '0, bus_data = '0;
    logic [3:0]  bus_be = '0;
    logic        bus_ready, bus_stop, rd_empty, seq_err;
    logic [35:0] rd_data;

    int tests = 0, fails = 0, seed = 0;
    logic [35:0] model_q[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    wfunnel_top dut_i (
        .clk(clk), .rst_n(rst_n), .cfg_single_i(cfg_single),
        .bus_start_i(bus_start), .bus_addr_i(bus_addr), .bus_valid_i(bus_valid),
        .bus_data_i(bus_data), .bus_be_i(bus_be), .bus_ready_o(bus_ready),
        .bus_stop_o(bus_stop), .rd_en_i(rd_en), .rd_data_o(rd_data),
        .rd_empty_o(rd_empty), .seq_err_o(seq_err)
    );

    typedef struct packed {
        logic [31:0] addr;
        logic [7:0]  n;
        logic        single;
        logic [7:0]  acc;
        logic        err;
    } vec_t;

    localparam int NV = 7;
    localparam vec_t VEC [NV] = '{
        '{32'h0040_0000, 8'd5, 1'b0, 8'd5, 1'b0},  // R2 R3 plain in-window burst
        '{32'h0100_0000, 8'd3, 1'b0, 8'd0, 1'b0},  // R2 outside window
        '{32'h007F_FFF8, 8'd4, 1'b0, 8'd2, 1'b0},  // R5 window end
        '{32'h0040_0100, 8'd3, 1'b1, 8'd1, 1'b0},  // R6 single mode
        '{32'h0040_0104, 8'd3, 1'b1, 8'd1, 1'b0},  // R7 correct restart
        '{32'h0040_0200, 8'd2, 1'b0, 8'd2, 1'b1},  // R8 wrong restart
        '{32'h0040_0300, 8'd1, 1'b0, 8'd1, 1'b1}   // R8 error stays set
    };

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic burst(input logic [31:0] a, input int n, input logic single,
                         output int acc, output logic stopped);
        logic r, s;
        acc = 0; stopped = 1'b0;
        @(negedge clk);
        cfg_single = single; bus_start = 1'b1; bus_addr = a; bus_valid = 1'b0;
        @(negedge clk);
        bus_start = 1'b0;
        for (int k = 0; k < n; k++) begin
            bus_valid = 1'b1;
            bus_data  = 32'hA500_0000 + 32'(seed);
            bus_be    = 4'(seed) | 4'b0001;
            #1;
            r = bus_ready; s = bus_stop;
            if (r) begin
                acc++; model_q.push_back({bus_be, bus_data}); seed++;
            end
            @(negedge clk);
            if (s) begin stopped = 1'b1; break; end
        end
        bus_valid = 1'b0;
        #1;
    endtask

    task automatic pop_one(input string req);
        logic [35:0] exp;
        rd_en = 1'b1;
        @(negedge clk);
        rd_en = 1'b0;
        exp = (model_q.size() != 0) ? model_q.pop_front() : 36'hX;
        chk(req, rd_data, exp);
    endtask

    task automatic drain(input string req, input int exp_n);
        int got = 0;
        @(negedge clk);
        while (!rd_empty && got < 40) begin
            pop_one(req);
            got++;
        end
        chk(req, 64'(got), 64'(exp_n));
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        model_q.delete();
        @(negedge clk);
    endtask

    task automatic summary();
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++; tests++;
        $display("FAIL watchdog actual=hung expected=done");
        summary();
    end

    initial begin
        int acc;
        logic st;

        do_reset();
        // R1 reset state
        chk("R1 empty", 64'(rd_empty), 1);
        chk("R1 err", 64'(seq_err), 0);
        chk("R1 ready", 64'(bus_ready), 0);
        chk("R1 stop", 64'(bus_stop), 0);

        for (int i = 0; i < NV; i++) begin
            burst(VEC[i].addr, int'(VEC[i].n), VEC[i].single, acc, st);
            chk($sformatf("R2 R3 R5 R6 row %0d accepted", i), 64'(acc), 64'(VEC[i].acc));
            chk($sformatf("R7 R8 row %0d error", i), 64'(seq_err), 64'(VEC[i].err));
            if (st) chk($sformatf("R5 row %0d closed", i), 64'(bus_ready), 0);
            drain($sformatf("R3 R10 row %0d words", i), int'(VEC[i].acc));
        end

        // R1 reset clears the sticky error
        do_reset();
        chk("R1 err cleared", 64'(seq_err), 0);
        chk("R1 empty again", 64'(rd_empty), 1);

        // R4 overfill: 16 accepted, 17th refused with stop
        burst(32'h0040_0000, 20, 1'b0, acc, st);
        chk("R4 accepted at full", 64'(acc), 16);
        chk("R4 stop at full", 64'(st), 1);
        chk("R4 closed", 64'(bus_ready), 0);
        for (int k = 0; k < 4; k++) pop_one("R9 R10 partial drain");

        // R7 restart at tracked address 0x0040_0040
        burst(32'h0040_0040, 4, 1'b0, acc, st);
        chk("R7 restart accepted", 64'(acc), 4);
        chk("R7 no error", 64'(seq_err), 0);
        drain("R10 words across full stop", 16);

        // R9 read while empty leaves pointer alone
        @(negedge clk);
        rd_en = 1'b1;
        @(negedge clk);
        rd_en = 1'b0;
        chk("R9 empty read", 64'(rd_empty), 1);
        burst(32'h0040_0800, 1, 1'b0, acc, st);
        chk("R9 push after empty read", 64'(acc), 1);
        drain("R9 oldest entry", 1);
        chk("R8 no error on fresh start", 64'(seq_err), 0);

        summary();
    end
endmodule